// File: doc/BRIEF.md
# D-Channel Timing Strobe and Burst-Clock Generator

This block produces the signalling-channel timing at the digital side of a basic-rate line transceiver. It follows a bit clock and a frame sync and marks the two bit times of each frame that carry signalling-channel data. A downstream layer-2 device uses these marks to shift data in and out. The block drives two output pins. The transmit pin marks when transmit data should be presented. The receive pin marks when receive data is valid.

A small command decoder takes bytes from a control port and chooses what each pin carries. By default each pin carries a level strobe that is high for two bit-clock periods. A pin-assignment command can park either pin low. One two-command sequence switches both pins to gated burst clocks for an external HDLC controller. In that mode each pin passes exactly two bit-clock pulses per frame. A mode-select command returns both pins to their defaults.

The whole block runs on a fast system clock. The bit clock and the frame sync are sampled as levels in that clock domain.

Top module: `dchan_strobe_gen`

## Requirements
- R1: While `rst` is high, and after it is released, the selector is 0 and burst mode is off. Both pins are low outside the signalling window and carry the level strobes.
- R2: Bit number 0 is the bit whose rising `bclk` edge sees `fsync` high. Each later rising edge adds one to the bit number. In strobe mode, an unparked pin rises after the falling `bclk` edge of bit `SLOT`. It falls after the falling edge of bit `SLOT+2`, so it is high for exactly two `bclk` periods. At all other times it is low.
- R3: The window repeats in every frame, once per frame, at the same bit position.
- R4: Bytes 0xE0 to 0xE7 store their low three bits as the selector. Selector bit 1 set parks `txPin` low. Selector bit 0 set parks `rxPin` low. Selector bit 2 has no effect on the pins.
- R5: Burst mode starts only when byte 0xF1 is the command that immediately follows 0xE1.
- R6: Any byte from 0xE0 to 0xE7 ends burst mode. If any other command comes between 0xE1 and 0xF1, burst mode is not entered. A 0xF1 with no 0xE1 just before it has no effect.
- R7: In burst mode both pins output `bclk` gated by an enable. Each pin is high only during the high phases of bits `SLOT+1` and `SLOT+2`, which gives exactly two pulses per frame. The falling edges of these pulses are the falling edges of `bclk`.
- R8: The burst gate enable changes only while `bclk` is low, so no partial pulse is produced.
- R9: Bytes 0x00 to 0x0F select a device mode. They return the selector to 0 and turn off burst mode.
- R10: Any other byte changes neither the pins nor the selector. It only cancels a pending 0xE1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bclk | input | 1 | Bit clock, sampled as a level |
| fsync | input | 1 | Frame sync, sampled on rising bclk |
| cmdValid | input | 1 | Command byte strobe, one clk cycle per byte |
| cmdByte | input | 8 | Command byte |
| txPin | output | 1 | Transmit strobe or transmit burst clock |
| rxPin | output | 1 | Receive strobe or receive burst clock |

## Verification
The assertions rely on three assumptions about the inputs. Each `bclk` phase lasts at least two system clocks. `fsync` rises once per frame, and a frame is longer than `SLOT+3` bits. Commands arrive only as single-cycle strobes. The bench builds `bclk` from a phase counter at 4 clocks per phase and holds `fsync` high for all of bit 0 of each 24-bit frame. It sends commands only at bit 12 or later, after the window has closed, so a change of mode never splits a window.

// File: rtl/dchan_pkg.sv
package dchan_pkg;
  localparam logic [4:0] PINDEF_HI = 5'b11100;
  localparam logic [7:0] CLKEN_CMD = 8'hF1;
  localparam logic [2:0] BURST_SEL = 3'd1;

  typedef struct packed {
    logic burstOn;
    logic parkTx;
    logic parkRx;
  } dchanCtrl_t;
endpackage

// File: rtl/dchan_ctrl.sv
module dchan_ctrl
  import dchan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte,
  output dchanCtrl_t ctrl
);
  logic [2:0] sel;
  logic       armed;
  logic       burstOn;

  logic isPinDef, isClkEn, isMode;
  always_comb begin
    isPinDef = (cmdByte[7:3] == PINDEF_HI);
    isClkEn  = (cmdByte == CLKEN_CMD);
    isMode   = (cmdByte[7:4] == 4'h0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel     <= '0;
      armed   <= 1'b0;
      burstOn <= 1'b0;
    end else if (cmdValid) begin
      if (isPinDef) begin
        sel     <= cmdByte[2:0];
        armed   <= (cmdByte[2:0] == BURST_SEL);
        burstOn <= 1'b0;
      end else if (isClkEn) begin
        burstOn <= burstOn | armed;
        armed   <= 1'b0;
      end else if (isMode) begin
        sel     <= '0;
        armed   <= 1'b0;
        burstOn <= 1'b0;
      end else begin
        armed   <= 1'b0;
      end
    end
  end

  assign ctrl = '{burstOn: burstOn, parkTx: sel[1], parkRx: sel[0]};

  // R5
  burst_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(burstOn) |-> $past(cmdValid && cmdByte == CLKEN_CMD && armed));

  // R6
  pindef_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cmdValid && cmdByte[7:3] == PINDEF_HI) |-> !burstOn);

  // R9
  mode_default_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cmdValid && cmdByte[7:4] == 4'h0) |-> (sel == 3'd0 && !burstOn));
endmodule

// File: rtl/dchan_timing.sv
module dchan_timing
  import dchan_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SLOT  = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bclk,
  input  logic       fsync,
  input  dchanCtrl_t ctrl,
  output logic       txPin,
  output logic       rxPin
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] WIN_A    = CNT_W'(SLOT);
  localparam logic [CNT_W-1:0] WIN_B    = CNT_W'(SLOT + 1);

  logic             bclkQ;
  logic             bclkRise, bclkFall;
  logic [CNT_W-1:0] bitCnt;
  logic             inWindow;
  logic             stbQ, gateQ;
  logic             txReg, rxReg;

  always_comb begin
    bclkRise = bclk & ~bclkQ;
    bclkFall = ~bclk & bclkQ;
    inWindow = (bitCnt == WIN_A) || (bitCnt == WIN_B);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclkQ  <= 1'b0;
      bitCnt <= '0;
      stbQ   <= 1'b0;
      gateQ  <= 1'b0;
      txReg  <= 1'b0;
      rxReg  <= 1'b0;
    end else begin
      bclkQ <= bclk;
      if (bclkRise) begin
        if (fsync)                 bitCnt <= '0;
        else if (bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
      end
      if (bclkFall) begin
        stbQ  <= inWindow;
        gateQ <= inWindow & ctrl.burstOn;
      end
      txReg <= stbQ & ~ctrl.parkTx;
      rxReg <= stbQ & ~ctrl.parkRx;
    end
  end

  always_comb begin
    txPin = ctrl.burstOn ? (bclk & gateQ) : txReg;
    rxPin = ctrl.burstOn ? (bclk & gateQ) : rxReg;
  end

  logic [2:0] pulseCnt;
  always_ff @(posedge clk) begin
    if (rst) pulseCnt <= '0;
    else if (bclkRise) begin
      if (fsync)                              pulseCnt <= '0;
      else if (gateQ && pulseCnt != 3'd7)     pulseCnt <= pulseCnt + 1'b1;
    end
  end

  // R8
  gate_low_chk: assert property (@(posedge clk) disable iff (rst)
    (gateQ != $past(gateQ)) |-> !$past(bclk));

  // R2
  strobe_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (stbQ != $past(stbQ)) |-> $past(bclkQ && !bclk));

  // R7
  pulse_limit_chk: assert property (@(posedge clk) disable iff (rst)
    pulseCnt <= 3'd2);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!txReg && !rxReg && !gateQ));
endmodule

// File: rtl/dchan_strobe_gen.sv
module dchan_strobe_gen
  import dchan_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SLOT  = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bclk,
  input  logic       fsync,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte,
  output logic       txPin,
  output logic       rxPin
);
  dchanCtrl_t ctrl;

  dchan_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdByte(cmdByte), .ctrl(ctrl)
  );

  dchan_timing #(.CNT_W(CNT_W), .SLOT(SLOT)) u_timing (
    .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync), .ctrl(ctrl),
    .txPin(txPin), .rxPin(rxPin)
  );
endmodule

// File: tb/sim_dchan_strobe_gen.sv
`timescale 1ns/1ps
module sim_dchan_strobe_gen;
  localparam int SLOT  = 6;
  localparam int FRAME = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b0;
  logic fsync = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdByte = 8'h00;
  logic txPin, rxPin;

  always #2.5 clk = ~clk;

  dchan_strobe_gen #(.CNT_W(8), .SLOT(SLOT)) u0 (
    .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .txPin(txPin), .rxPin(rxPin)
  );

  int errors = 0;
  int checks = 0;
  int phase = 7;
  int bitIdx = FRAME - 1;
  bit checkEn = 0;
  bit done = 0;
  string curReq = "R1 R2 R3";

  logic [2:0] mSel = 3'd0;
  bit mArm = 0;
  bit mBurst = 0;

  function automatic logic expPin(input bit isTx, input int k, input bit hi);
    bit win;
    bit park;
    win = hi ? (k == SLOT+1 || k == SLOT+2) : (k == SLOT || k == SLOT+1);
    if (mBurst) return hi && win;
    park = isTx ? mSel[1] : mSel[0];
    return win && !park;
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // pattern generator and continuous checker
  always @(negedge clk) begin
    if (rst && phase == 3) begin
      check("R1", "txPin in reset", txPin, 1'b0);
      check("R1", "rxPin in reset", rxPin, 1'b0);
    end
    if (checkEn && !done && (phase == 3 || phase == 7)) begin
      check(curReq, $sformatf("txPin bit %0d ph %0d", bitIdx, phase), txPin,
            expPin(1'b1, bitIdx, phase == 3));
      check(curReq, $sformatf("rxPin bit %0d ph %0d", bitIdx, phase), rxPin,
            expPin(1'b0, bitIdx, phase == 3));
    end
    phase = (phase + 1) % 8;
    if (phase == 0) begin
      bitIdx = (bitIdx + 1) % FRAME;
      if (bitIdx == 0 && !rst) checkEn = 1;
    end
    bclk  <= (phase < 4);
    fsync <= (bitIdx == 0);
  end

  task automatic waitQuiet();
    do @(negedge clk); while (!(bitIdx == 12 && phase == 1));
  endtask

  task automatic waitFrames(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!(bitIdx == 0 && phase == 1));
    end
  endtask

  task automatic sendCmd(input logic [7:0] c);
    cmdValid <= 1'b1;
    cmdByte  <= c;
    if (c[7:3] == 5'b11100) begin
      mSel = c[2:0]; mArm = (c[2:0] == 3'd1); mBurst = 0;
    end else if (c == 8'hF1) begin
      mBurst = mBurst | mArm; mArm = 0;
    end else if (c[7:4] == 4'h0) begin
      mSel = 3'd0; mArm = 0; mBurst = 0;
    end else begin
      mArm = 0;
    end
    @(negedge clk);
    cmdValid <= 1'b0;
    @(negedge clk);
  endtask

  task automatic step(input string req, input logic [7:0] a);
    waitQuiet(); curReq = req; sendCmd(a); waitFrames(2);
  endtask

  logic [7:0] pool [10] = '{8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE5, 8'hE7,
                             8'hF1, 8'hF0, 8'h04, 8'h5A};

  initial begin
    void'($urandom(32'h1234abcd));
    repeat (40) @(negedge clk);
    rst = 1'b0;
    waitFrames(3);
    // R4 parking
    step("R4 park rx", 8'hE1);
    step("R4 park tx", 8'hE2);
    step("R4 bit2 ignored", 8'hE4);
    step("R4 park both", 8'hE3);
    step("R9 mode select", 8'h02);
    // R5 sequence
    waitQuiet(); curReq = "R5 E1 F1 burst";
    sendCmd(8'hE1); sendCmd(8'hF1); waitFrames(3);
    step("R7 F1 again stays", 8'hF1);
    step("R10 other byte ignored", 8'h5A);
    step("R6 pindef exits", 8'hE0);
    waitQuiet(); curReq = "R6 E2 F1 no burst";
    sendCmd(8'hE2); sendCmd(8'hF1); waitFrames(2);
    waitQuiet(); curReq = "R6 E1 x F1 no burst";
    sendCmd(8'hE1); sendCmd(8'h5A); sendCmd(8'hF1); waitFrames(2);
    step("R6 lone F1", 8'hF1);
    waitQuiet(); curReq = "R8 burst";
    sendCmd(8'hE1); sendCmd(8'hF1); waitFrames(2);
    step("R9 mode exits burst", 8'h07);
    // random sequences
    for (int it = 0; it < 40; it++) begin
      int n;
      waitQuiet();
      curReq = "R4 R5 R6 R7 R10 random";
      n = 1 + ($urandom % 3);
      for (int j = 0; j < n; j++) sendCmd(pool[$urandom % 10]);
      waitFrames(1);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    checks++;
    done = 1;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule